// File: doc/BRIEF.md
# Keyed Configuration Lock for a Flash Controller

This block sits in front of the configuration state of a flash memory controller. It holds an interface configuration register, a timing register and a command register, all written through one register write port. The configuration and timing registers are protected. A write to either one takes effect only if a 16-bit unlock key was written to the lock register beforehand. Each key write opens the protected registers for a single write, and the lock then closes again without any further action.

Writing the reset opcode to the command register resets the controller. While that reset runs, the write port applies back-pressure. A write is accepted on a clock edge only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole reset pulse, and a master must hold `wr_valid` and its payload steady until the write is accepted. The configuration flags drive the rest of the controller. The timing word goes to a separate strobe generator.

Word addresses: 0 = command register, 1 = interface configuration, 2 = timing, 3 = lock. Other addresses are unmapped.

Top module: `flash_cfg_lock`

## Requirements
- R1: After `rst_n` is released, the outputs are: configuration flags 0, `timing` 0, `unlocked` 0, `prot_violation` 0, `ctrl_reset` 0 and `wr_ready` 1.
- R2: Address 3 is the lock register. An accepted write there with `wr_be[1:0]`=2'b11 and `wr_data[15:0]`=16'hA25E sets `unlocked` on the next cycle. `wr_data[31:16]` is ignored.
- R3: While unlocked, the next accepted write to address 1 or 2 updates that register and clears `unlocked`. A second write that has no new key is ignored.
- R4: A write to address 1 or 2 while locked leaves both registers unchanged and sets `prot_violation`. The flag stays set until `rst_n` or a controller reset clears it.
- R5: Any other lock-register write closes the lock. This covers a wrong value, and also `wr_be[1:0]` other than 2'b11.
- R6: Configuration register fields, all written under byte enable 0: bit 3 is `cfg_wp` (write protect), bit 2 is `cfg_large_page`, bit 1 is `cfg_long_addr` (five address cycles) and bit 0 is `cfg_wide_bus` (16-bit bus).
- R7: The timing register is `TIM_W` (27) bits wide. On a permitted write, only the byte lanes whose `wr_be` bit is set change.
- R8: Writing 8'hFF with `wr_be[0]` to address 0 raises `ctrl_reset` from the next cycle for `RST_CYCLES` (4) cycles, with `wr_ready` low for that time. It clears `unlocked` and `prot_violation` and keeps the configuration and timing values.
- R9: Every accepted address-0 write with `wr_be[0]` pulses `cmd_stb` for one cycle, with `cmd_code` = `wr_data[7:0]`. Any code other than 8'hFF causes no reset.
- R10: Writes to the command register with a code other than 8'hFF, and writes to unmapped addresses, do not consume an open unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted (low during controller reset) |
| wr_addr | input | AW (4) | Word address |
| wr_data | input | DW (32) | Write data |
| wr_be | input | DW/8 (4) | Byte enables |
| cfg_wp | output | 1 | Write protect flag |
| cfg_large_page | output | 1 | Large-block page mode |
| cfg_long_addr | output | 1 | Five-cycle addressing |
| cfg_wide_bus | output | 1 | 16-bit bus |
| timing | output | TIM_W (27) | Timing word for the strobe generator |
| unlocked | output | 1 | One protected write is permitted |
| prot_violation | output | 1 | Sticky locked-write flag |
| cmd_stb | output | 1 | Command written this cycle |
| cmd_code | output | 8 | Last command opcode |
| ctrl_reset | output | 1 | Controller reset pulse |

## Verification
Suppose the lock state is wrong, for example the key is left open after a protected write or is cleared too early. The effect shows up one cycle after the next protected write: a register changes when it should hold, or it holds while `prot_violation` rises. A wrong reset counter shows as a `ctrl_reset` pulse of the wrong length, and `wr_ready` stays low for the same wrong number of cycles. A lane-enable fault corrupts timing bits that the bench checks right after the write. Each write is compared on the cycle after it is accepted, so any fault is caught at that same write.

// File: rtl/flash_cfg_lock_pkg.sv
package flash_cfg_lock_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'hA25E;
  localparam logic [7:0]  OP_RESET   = 8'hFF;
  localparam int unsigned A_CMD  = 0;
  localparam int unsigned A_CFG  = 1;
  localparam int unsigned A_TIM  = 2;
  localparam int unsigned A_LOCK = 3;

  typedef struct packed {
    logic wp;
    logic large_page;
    logic long_addr;
    logic wide_bus;
  } cfg_t;
endpackage

// File: rtl/flash_key_gate.sv
module flash_key_gate
  import flash_cfg_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc,
  input  logic        sel_lock,
  input  logic        sel_prot,
  input  logic [15:0] key_data,
  input  logic [1:0]  key_be,
  input  logic        clr,
  output logic        unlocked
);
  logic unl_q;
  logic key_ok;

  assign key_ok   = (key_be == 2'b11) && (key_data == UNLOCK_KEY);
  assign unlocked = unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                unl_q <= 1'b0;
    else if (clr)              unl_q <= 1'b0;
    else if (acc && sel_lock)  unl_q <= key_ok;
    else if (acc && sel_prot)  unl_q <= 1'b0;
  end

  // R3: an open lock is spent by one protected write
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_q && acc && sel_prot) |=> !unl_q);

  // R8: controller reset closes the lock
  a_r8_clr_closes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !unl_q);
endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
  import flash_cfg_lock_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned TIM_W = 27,
  localparam int unsigned BE_W  = DW / 8,
  localparam int unsigned LANES = (TIM_W + 7) / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             sel_cfg,
  input  logic             sel_tim,
  input  logic             unlocked,
  input  logic [DW-1:0]    data,
  input  logic [BE_W-1:0]  be,
  input  logic             clr_viol,
  output cfg_t             cfg,
  output logic [TIM_W-1:0] tim,
  output logic             viol
);
  cfg_t             cfg_q;
  logic [TIM_W-1:0] tim_q;
  logic             viol_q;
  logic             wr_cfg, wr_tim, bad_wr;

  assign wr_cfg = acc && sel_cfg && unlocked;
  assign wr_tim = acc && sel_tim && unlocked;
  assign bad_wr = acc && (sel_cfg || sel_tim) && !unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n)               cfg_q <= '0;
    else if (wr_cfg && be[0]) cfg_q <= cfg_t'(data[3:0]);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LO = g * 8;
    localparam int unsigned LW = ((TIM_W - LO) >= 8) ? 8 : (TIM_W - LO);
    always_ff @(posedge clk) begin
      if (!rst_n)               tim_q[LO +: LW] <= '0;
      else if (wr_tim && be[g]) tim_q[LO +: LW] <= data[LO +: LW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        viol_q <= 1'b0;
    else if (clr_viol) viol_q <= 1'b0;
    else if (bad_wr)   viol_q <= 1'b1;
  end

  assign cfg  = cfg_q;
  assign tim  = tim_q;
  assign viol = viol_q;

  // R4: locked writes leave the protected state untouched
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel_cfg && !unlocked) |=> $stable(cfg_q));
  a_r4_tim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel_tim && !unlocked) |=> $stable(tim_q));
  // R4: the violation flag is sticky
  a_r4_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_q && !clr_viol) |=> viol_q);
endmodule

// File: rtl/flash_cmd_reset.sv
module flash_cmd_reset
  import flash_cfg_lock_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned CW = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       sel_cmd,
  input  logic [7:0] op,
  input  logic       be0,
  output logic [7:0] cmd_code,
  output logic       cmd_stb,
  output logic       ctrl_rst,
  output logic       reset_fire
);
  logic [CW-1:0] cnt_q;
  logic [7:0]    code_q;
  logic          stb_q;
  logic          take;

  assign take       = acc && sel_cmd && be0;
  assign reset_fire = take && (op == OP_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= take;
      if (take) code_q <= op;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (reset_fire)    cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cmd_code = code_q;
  assign cmd_stb  = stb_q;
  assign ctrl_rst = (cnt_q != '0);

  // R8: reset opcode starts the pulse on the next cycle
  a_r8_rst_start: assert property (@(posedge clk) disable iff (!rst_n)
    reset_fire |=> ctrl_rst);
  // R9: any accepted command produces a strobe
  a_r9_stb: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> cmd_stb);
endmodule

// File: rtl/flash_cfg_lock.sv
module flash_cfg_lock
  import flash_cfg_lock_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 32,
  parameter int unsigned TIM_W      = 27,
  parameter int unsigned RST_CYCLES = 4,
  localparam int unsigned BE_W = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [BE_W-1:0]  wr_be,
  output logic             cfg_wp,
  output logic             cfg_large_page,
  output logic             cfg_long_addr,
  output logic             cfg_wide_bus,
  output logic [TIM_W-1:0] timing,
  output logic             unlocked,
  output logic             prot_violation,
  output logic             cmd_stb,
  output logic [7:0]       cmd_code,
  output logic             ctrl_reset
);
  logic acc, sel_cmd, sel_cfg, sel_tim, sel_lock, fire, unl;
  cfg_t cfg;

  assign acc      = wr_valid && wr_ready;
  assign sel_cmd  = (wr_addr == AW'(A_CMD));
  assign sel_cfg  = (wr_addr == AW'(A_CFG));
  assign sel_tim  = (wr_addr == AW'(A_TIM));
  assign sel_lock = (wr_addr == AW'(A_LOCK));
  assign wr_ready = !ctrl_reset;

  flash_cmd_reset #(.RST_CYCLES(RST_CYCLES)) i_cmd (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel_cmd(sel_cmd),
    .op(wr_data[7:0]), .be0(wr_be[0]),
    .cmd_code(cmd_code), .cmd_stb(cmd_stb),
    .ctrl_rst(ctrl_reset), .reset_fire(fire)
  );

  flash_key_gate i_key (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel_lock(sel_lock),
    .sel_prot(sel_cfg || sel_tim), .key_data(wr_data[15:0]),
    .key_be(wr_be[1:0]), .clr(fire), .unlocked(unl)
  );

  flash_prot_regs #(.DW(DW), .TIM_W(TIM_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .sel_cfg(sel_cfg),
    .sel_tim(sel_tim), .unlocked(unl), .data(wr_data), .be(wr_be),
    .clr_viol(fire), .cfg(cfg), .tim(timing), .viol(prot_violation)
  );

  assign unlocked       = unl;
  assign cfg_wp         = cfg.wp;
  assign cfg_large_page = cfg.large_page;
  assign cfg_long_addr  = cfg.long_addr;
  assign cfg_wide_bus   = cfg.wide_bus;

  // R8: a controller reset leaves configuration and timing intact
  a_r8_keep_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($stable(cfg) && $stable(timing)));
endmodule

// File: tb/test_flash_cfg_lock.sv
module test_flash_cfg_lock;
  localparam int TIM_W = 27;
  localparam int RSTC  = 4;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready;
  logic [3:0] wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] wr_be = 0;
  logic cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus;
  logic [TIM_W-1:0] timing;
  logic unlocked, prot_violation, cmd_stb, ctrl_reset;
  logic [7:0] cmd_code;

  always #2 clk = ~clk;

  flash_cfg_lock i_flash_cfg_lock (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .cfg_wp(cfg_wp), .cfg_large_page(cfg_large_page),
    .cfg_long_addr(cfg_long_addr), .cfg_wide_bus(cfg_wide_bus),
    .timing(timing), .unlocked(unlocked), .prot_violation(prot_violation),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code), .ctrl_reset(ctrl_reset)
  );

  int n_chk = 0, n_fail = 0;

  typedef struct {
    logic [3:0]       cfg;
    logic [TIM_W-1:0] tim;
    logic             unl;
    logic             viol;
    string            tag;
  } exp_t;
  exp_t sbq[$];

  logic [3:0]       m_cfg = 0;
  logic [TIM_W-1:0] m_tim = 0;
  logic             m_unl = 0, m_viol = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // monitor: compare the registered state the cycle after each write
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus} == e.cfg, {e.tag, " cfg"},
          32'({cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus}), 32'(e.cfg));
      chk(timing == e.tim, {e.tag, " timing"}, 32'(timing), 32'(e.tim));
      chk(unlocked == e.unl, {e.tag, " unlocked"}, 32'(unlocked), 32'(e.unl));
      chk(prot_violation == e.viol, {e.tag, " violation"}, 32'(prot_violation), 32'(e.viol));
    end
  end

  // driver: one accepted write, model update, expectation pushed
  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be, input string tag);
    exp_t e;
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1;
    wr_valid = 0;
    case (a)
      4'd0: if (be[0]) begin
        chk(cmd_stb === 1'b1 && cmd_code == d[7:0], {tag, " R9 strobe"}, {23'd0, cmd_stb, cmd_code}, {24'd1, d[7:0]});
        if (d[7:0] == 8'hFF) begin m_unl = 0; m_viol = 0; end
      end
      4'd1, 4'd2: if (m_unl) begin
        m_unl = 0;
        if (a == 4'd1) begin
          if (be[0]) m_cfg = d[3:0];
        end else begin
          for (int l = 0; l < 4; l++)
            if (be[l]) for (int b = 0; b < 8; b++)
              if (l*8+b < TIM_W) m_tim[l*8+b] = d[l*8+b];
        end
      end else m_viol = 1;
      4'd3: m_unl = (be[1:0] == 2'b11) && (d[15:0] == 16'hA25E);
      default: ;
    endcase
    e.cfg = m_cfg; e.tim = m_tim; e.unl = m_unl; e.viol = m_viol; e.tag = tag;
    sbq.push_back(e);
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus} == 0, "R1 cfg", 32'({cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus}), 0);
    chk(timing == 0, "R1 timing", 32'(timing), 0);
    chk({unlocked, prot_violation, ctrl_reset} == 0, "R1 flags", 32'({unlocked, prot_violation, ctrl_reset}), 0);
    chk(wr_ready == 1, "R1 ready", 32'(wr_ready), 1);

    wr(1, 32'hF, 4'hF, "R4 locked cfg");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(1, 32'h6, 4'h1, "R3 R6 cfg open");
    @(negedge clk);
    chk(!cfg_wp && cfg_large_page && cfg_long_addr && !cfg_wide_bus, "R6 fields",
        32'({cfg_wp, cfg_large_page, cfg_long_addr, cfg_wide_bus}), 32'h6);
    wr(1, 32'h9, 4'h1, "R3 second write");
    wr(3, 32'hFFFF_A25E, 4'hF, "R2 upper ignored");
    wr(3, 32'h0000_1234, 4'b0011, "R5 wrong key");
    wr(1, 32'h1, 4'h1, "R5 closed cfg");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(3, 32'h0000_A25E, 4'b0001, "R5 partial key");
    wr(2, 32'h0000_0055, 4'hF, "R5 closed tim");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(2, 32'hFFFF_FFFF, 4'hF, "R7 timing full");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(2, 32'h0012_3400, 4'b0010, "R7 lane 1");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(0, 32'h30, 4'h1, "R9 R10 cmd");
    wr(5, 32'h77, 4'hF, "R10 unmapped");
    wr(1, 32'hB, 4'h1, "R10 cfg after cmd");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(0, 32'hFF, 4'h1, "R8 reset cmd");
    begin
      int n = 0;
      chk(ctrl_reset == 1 && wr_ready == 0, "R8 pulse start", 32'({ctrl_reset, wr_ready}), 32'h2);
      @(negedge clk);
      while (ctrl_reset && n < 50) begin
        n++;
        chk(!wr_ready, "R8 ready low", 32'(wr_ready), 0);
        @(negedge clk);
      end
      chk(n == RSTC, "R8 pulse length", 32'(n), 32'(RSTC));
    end
    wr(2, 32'h1, 4'hF, "R8 R4 locked after reset");
    wr(3, 32'h0000_A25E, 4'b0011, "R2 key");
    wr(0, 32'hFF, 4'h1, "R8 clears");
    wr(1, 32'h2, 4'h1, "R8 held write");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule